// File: doc/BRIEF.md
# Programmable Sum-of-Products Input Array with Shared Control Terms

This block is the AND-plane front end of one logic block in a small programmable logic device. A routing matrix delivers a bus of signals to it. The array forms the true and complement literal of each signal. A configurable mask then connects literals into each AND term. Most of the terms feed the macrocells as general logic. Four more terms are shared by the whole block: two output-enable terms, a term that drives the asynchronous clear of every flip-flop, and a term that drives their asynchronous set.

Each pin of the block has a three-state driver with its own enable mode. The driver can be forced off, forced on, or controlled by one of the two shared enable terms. A disabled pin drives high impedance. A single parallel write port loads the configuration, one word per address. The AND evaluation is purely combinational from the routed inputs and the stored masks.

Top module: `pla_and_plane`

## Requirements
- R1: While reset is held and right after it, every fuse of every term is connected, so all logic terms, the clear term and the set term read 0. Every pin mode is 2'b00 (disabled), so `pin_oe` is 0.
- R2: In a term's fuse word, bit 2k connects the true literal of input k and bit 2k+1 connects its complement. The term is the AND of all connected literals, and it is updated combinationally from `sw_in`.
- R3: A term with no fuse connected evaluates to 1 for every input value.
- R4: A term with both the true and the complement fuse of the same input connected evaluates to 0 for every input value.
- R5: A write with `cfg_we` high stores `cfg_data` at `cfg_addr`, and it takes effect on the next rising clock edge. Addresses 0..63 hold the logic terms, 64 holds enable term 0, 65 enable term 1, 66 the clear term and 67 the set term.
- R6: Address 68 holds the pin-mode word. Pin p uses bits [3p+1:3p] as its mode and bit 3p+2 to select the enable term (0 selects term 0, 1 selects term 1). Mode 2'b00 is disabled, 2'b01 is always enabled, and 2'b10 or 2'b11 is term-controlled.
- R7: A disabled pin has `pin_oe` low and drives high impedance on `pin_io`.
- R8: An always-enabled pin has `pin_oe` high and drives `pin_d` on `pin_io`, whatever the enable terms are.
- R9: A term-controlled pin follows the enable term that its select bit names, and both enable terms are shared by all pins.
- R10: `clr_term` and `set_term` are the single clear and set terms evaluated from `sw_in`, and they are common to the whole block.
- R11: A write to an address above 68, or any cycle with `cfg_we` low, changes no stored configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_data | input | 44 | Configuration word (fuse mask or pin-mode word) |
| sw_in | input | 22 | Signals from the routing matrix |
| pin_d | input | 8 | Data from the output macrocells to the pins |
| pt_out | output | 64 | Logic AND terms |
| clr_term | output | 1 | Shared asynchronous clear term |
| set_term | output | 1 | Shared asynchronous set term |
| pin_oe | output | 8 | Resolved output enable for each pin |
| pin_io | output | 8 | Three-state pin drive, 'z when disabled |

## Verification
The assertions assume that `cfg_addr` and `cfg_data` are valid whenever `cfg_we` is high. They also assume that `sw_in` is settled before the clock edge at which the term outputs are sampled. The bench changes its inputs only on falling edges, holds a write for exactly one rising edge, and samples results on the following falling edge. This keeps every combinational path settled when it is observed. Writes to unused addresses are issued deliberately, with data that would be visible if it were stored.

// File: rtl/pla_pkg.sv
package pla_pkg;
   typedef enum logic [1:0] {
      PIN_OFF = 2'b00,
      PIN_ON  = 2'b01,
      PIN_PT0 = 2'b10,
      PIN_PT1 = 2'b11
   } pin_mode_e;

   localparam int N_SPECIAL = 4;
   localparam int SP_OE0    = 0;
   localparam int SP_OE1    = 1;
   localparam int SP_CLR    = 2;
   localparam int SP_SET    = 3;

   function automatic logic fuse_conflict(input logic [63:0] mask, input int n_in);
      logic c;
      c = 1'b0;
      for (int k = 0; k < n_in; k++)
         c = c | (mask[2*k] & mask[2*k+1]);
      return c;
   endfunction
endpackage

// File: rtl/pla_term.sv
module pla_term #(
   parameter int N_IN = 22
) (
   input  logic [N_IN-1:0]   x,
   input  logic [2*N_IN-1:0] fuse,
   output logic              term
);
   always_comb begin
      term = 1'b1;
      for (int k = 0; k < N_IN; k++) begin
         if (fuse[2*k]   && !x[k]) term = 1'b0;
         if (fuse[2*k+1] &&  x[k]) term = 1'b0;
      end
   end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
   parameter int N_ENT  = 69,
   parameter int DATA_W = 44,
   parameter int ADDR_W = 7,
   parameter int MODE_IDX = 68
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             data,
   output logic [N_ENT-1:0][DATA_W-1:0]  word_q
);
   initial begin
      if (N_ENT > (1 << ADDR_W))
         $error("pla_cfg_store: address width too narrow");
      if (MODE_IDX >= N_ENT)
         $error("pla_cfg_store: mode index outside store");
   end

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[e] <= (e == MODE_IDX) ? '0 : '1;
         else if (we && (int'(addr) == e))
            word_q[e] <= data;
      end
   end

   // R5: a valid write lands on the next edge
   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) < N_ENT) |=> word_q[$past(addr)] == $past(data));
   // R11: no write strobe, no change
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(word_q));
   // R11: out-of-range address leaves the store alone
   a_r11_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) >= N_ENT) |=> $stable(word_q));
endmodule

// File: rtl/pla_pin_ctl.sv
module pla_pin_ctl #(
   parameter int N_OE  = 2,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] sel,
   input  logic [N_OE-1:0]  oe_terms,
   input  logic             d,
   output logic             oe,
   output logic             pad
);
   import pla_pkg::*;
   logic pt_en;

   if (N_OE == 1) begin : g_single
      assign pt_en = oe_terms[0];
      logic unused_sel;
      assign unused_sel = ^sel;
   end else begin : g_multi
      assign pt_en = (int'(sel) < N_OE) ? oe_terms[sel] : 1'b0;
   end

   always_comb begin
      unique case (pin_mode_e'(mode))
         PIN_OFF:          oe = 1'b0;
         PIN_ON:           oe = 1'b1;
         PIN_PT0, PIN_PT1: oe = pt_en;
         default:          oe = 1'b0;
      endcase
   end

   assign pad = oe ? d : 1'bz;

   a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> !oe);
   a_r8_on_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> oe);
   a_r9_follow_term: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && int'(sel) < N_OE) |-> (oe == oe_terms[sel]));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N_IN  = 22,
   parameter int N_PT  = 64,
   parameter int N_PIN = 8,
   parameter int N_OE  = 2,
   localparam int FUSE_W  = 2 * N_IN,
   localparam int N_TERMS = N_PT + pla_pkg::N_SPECIAL,
   localparam int MODE_IDX = N_TERMS,
   localparam int N_ENT   = N_TERMS + 1,
   localparam int ADDR_W  = $clog2(N_ENT),
   localparam int SEL_W   = (N_OE > 1) ? $clog2(N_OE) : 1,
   localparam int MODE_W  = 2 + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [FUSE_W-1:0] cfg_data,
   input  logic [N_IN-1:0]   sw_in,
   input  logic [N_PIN-1:0]  pin_d,
   output logic [N_PT-1:0]   pt_out,
   output logic              clr_term,
   output logic              set_term,
   output logic [N_PIN-1:0]  pin_oe,
   output logic [N_PIN-1:0]  pin_io
);
   import pla_pkg::*;

   initial begin
      if (N_PIN * MODE_W > FUSE_W)
         $error("pla_and_plane: pin-mode word wider than config word");
      if (N_OE < 1 || N_OE > 2)
         $error("pla_and_plane: N_OE must be 1 or 2");
      if (N_IN > 32)
         $error("pla_and_plane: N_IN above 32 not supported");
   end

   logic [N_ENT-1:0][FUSE_W-1:0] word_q;
   logic [N_TERMS-1:0]           term_v;
   logic [N_OE-1:0]              oe_terms;
   logic [FUSE_W-1:0]            mode_word;

   pla_cfg_store #(
      .N_ENT(N_ENT), .DATA_W(FUSE_W), .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .data(cfg_data), .word_q(word_q)
   );

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      pla_term #(.N_IN(N_IN)) u_term (
         .x(sw_in), .fuse(word_q[t]), .term(term_v[t])
      );

      // R3: empty mask reads 1
      a_r3_empty_high: assert property (@(posedge clk) disable iff (!rst_n)
         (word_q[t] == '0) |-> term_v[t]);
      // R4: contradictory literals read 0
      a_r4_conflict_low: assert property (@(posedge clk) disable iff (!rst_n)
         fuse_conflict(64'(word_q[t]), N_IN) |-> !term_v[t]);
   end

   assign pt_out   = term_v[N_PT-1:0];
   assign clr_term = term_v[N_PT + SP_CLR];
   assign set_term = term_v[N_PT + SP_SET];
   assign oe_terms = term_v[N_PT + N_OE - 1 : N_PT];
   assign mode_word = word_q[MODE_IDX];

   if (N_OE == 1) begin : g_oe1_unused
      logic unused_oe1;
      assign unused_oe1 = term_v[N_PT + SP_OE1];
   end

   for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      pla_pin_ctl #(.N_OE(N_OE), .SEL_W(SEL_W)) u_pin (
         .clk(clk), .rst_n(rst_n),
         .mode(mode_word[p*MODE_W +: 2]),
         .sel(mode_word[p*MODE_W + 2 +: SEL_W]),
         .oe_terms(oe_terms),
         .d(pin_d[p]),
         .oe(pin_oe[p]),
         .pad(pin_io[p])
      );
   end

   // R1: first cycle after reset: array erased, pins off
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pt_out == '0 && !clr_term && !set_term));
   // R10: clear/set terms follow their own masks only
   a_r10_clr_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q[N_PT + SP_CLR] == '0) |-> clr_term);
   a_r10_set_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q[N_PT + SP_SET] == '0) |-> set_term);
endmodule

// File: tb/tb_pla_and_plane.sv
module tb_pla_and_plane;
   localparam int N_IN = 22, N_PT = 64, N_PIN = 8;

   logic clk = 0, rst_n = 0, cfg_we = 0;
   logic [6:0]  cfg_addr = '0;
   logic [43:0] cfg_data = '0;
   logic [21:0] sw_in = '0;
   logic [7:0]  pin_d = '0;
   logic [63:0] pt_out;
   logic clr_term, set_term;
   logic [7:0] pin_oe, pin_io;

   int tests = 0, fails = 0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #5 clk = ~clk;

   pla_and_plane dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [43:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 7'(a); cfg_data = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   function automatic logic [43:0] lit(input int k, input bit comp);
      logic [43:0] m = '0;
      m[2*k + (comp ? 1 : 0)] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] exp_sweep(input logic [21:0] v);
      logic [63:0] e;
      for (int i = 0; i < N_PT; i++)
         e[i] = v[i % N_IN] & ~v[(i + 5) % N_IN];
      return e;
   endfunction

   function automatic logic [2:0] pm(input logic [1:0] mode, input bit sel);
      return {sel, mode};
   endfunction

   initial begin
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [43:0] mw;
      logic [63:0] snap;
      repeat (3) @(negedge clk);
      // R1 reset state
      sw_in = 22'h2AAAAA;
      chk("R1 pt", pt_out, 64'd0);
      chk("R1 oe", {56'd0, pin_oe}, 64'd0);
      chk("R1 clr/set", {62'd0, clr_term, set_term}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release", pt_out, 64'd0);

      // R2/R5: load every logic term
      for (int i = 0; i < N_PT; i++)
         wr(i, lit(i % N_IN, 0) | lit((i + 5) % N_IN, 1));
      sw_in = '0;     #1 chk("R2 zeros", pt_out, exp_sweep(sw_in));
      sw_in = '1;     #1 chk("R2 ones", pt_out, exp_sweep(sw_in));
      for (int n = 0; n < 40; n++) begin
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         sw_in = lfsr[21:0];
         #1 chk("R2 random", pt_out, exp_sweep(sw_in));
      end
      for (int k = 0; k < N_IN; k++) begin
         sw_in = 22'(1) << k;
         #1 chk("R2 walk", pt_out, exp_sweep(sw_in));
      end

      // R5 timing: new value only after the edge
      sw_in = 22'h000001;   // term 0 expects 1 with current mask
      @(negedge clk);
      cfg_we = 1; cfg_addr = 7'd0; cfg_data = lit(1, 0);
      #1 chk("R5 before edge", {63'd0, pt_out[0]}, 64'd1);
      @(negedge clk); cfg_we = 0;
      chk("R5 after edge", {63'd0, pt_out[0]}, 64'd0);

      // R3 empty term, R4 conflicting term
      wr(3, '0);
      wr(5, lit(7, 0) | lit(7, 1) | lit(2, 0));
      for (int n = 0; n < 8; n++) begin
         sw_in = (n == 0) ? '0 : (n == 1) ? '1 : 22'(n * 22'h05A3C1);
         #1;
         chk("R3 empty", {63'd0, pt_out[3]}, 64'd1);
         chk("R4 conflict", {63'd0, pt_out[5]}, 64'd0);
      end

      // R10 shared clear/set terms: clr = in2, set = ~in3
      wr(66, lit(2, 0));
      wr(67, lit(3, 1));
      for (int v = 0; v < 4; v++) begin
         sw_in = 22'(v) << 2;
         #1 chk("R10 clr/set", {62'd0, clr_term, set_term},
                {62'd0, 1'(v & 1), 1'(((v >> 1) & 1) == 0)});
      end

      // R6..R9 pins: oe0 = in0, oe1 = in1
      wr(64, lit(0, 0));
      wr(65, lit(1, 0));
      mw = '0;
      mw[2:0]   = pm(2'b00, 0);
      mw[5:3]   = pm(2'b01, 0);
      mw[8:6]   = pm(2'b10, 0);
      mw[11:9]  = pm(2'b10, 1);
      mw[14:12] = pm(2'b11, 0);
      mw[17:15] = pm(2'b11, 1);
      mw[20:18] = pm(2'b01, 1);
      mw[23:21] = pm(2'b00, 1);
      wr(68, mw);
      for (int v = 0; v < 4; v++) begin
         logic o0, o1;
         logic [7:0] eoe;
         o0 = 1'(v & 1); o1 = 1'((v >> 1) & 1);
         eoe = {1'b0, 1'b1, o1, o0, o1, o0, 1'b1, 1'b0};
         sw_in = 22'(v);
         pin_d = 8'(8'h5C ^ (v * 8'h33));
         #1;
         chk("R6/R7/R8/R9 oe", {56'd0, pin_oe}, {56'd0, eoe});
         chk("R8/R9 drive", {56'd0, pin_io & eoe}, {56'd0, pin_d & eoe});
      end

      // R11: ignored writes
      sw_in = 22'h0F0F0F;
      #1 snap = pt_out;
      wr(100, '0);
      wr(127, '0);
      chk("R11 bad addr", pt_out, snap);
      @(negedge clk);
      cfg_addr = 7'd68; cfg_data = '0;   // strobe stays low
      @(negedge clk);
      cfg_addr = 7'd10;
      @(negedge clk);
      chk("R11 no strobe pt", pt_out, snap);
      sw_in = 22'd3;
      #1 chk("R11 no strobe pins", {56'd0, pin_oe}, {56'd0, 8'b01111110});

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule